// File: doc/BRIEF.md
# Pairwise Interaction Sequencer with Minimum-Image Displacement

The block holds the coordinates of up to a fixed maximum number of particles, each with three signed fixed-point axes, in an internal store. After the particle count is set and a start pulse arrives, it walks every ordered pair of distinct particles through one flattened loop. For each pair it streams out the minimum-image displacement within a periodic box, the squared distance, and a flag that marks pairs closer than a cutoff. A running tally of within-cutoff pairs is kept for each first particle. It restarts with that particle's first pair and its final value comes out on the last pair of the group.

A host loads coordinates through a write port while the block is idle. It sets the particle count, the three half box lengths and the squared cutoff, then pulses start. The block reads both particles, wraps the displacement, and presents the result on a valid/ready stream, three clocks per pair when the consumer never stalls. A one-cycle done pulse follows the final pair. Force evaluation is left to downstream logic.

Top module: `pair_sweep`

## Requirements
- R1: After reset `busy`, `done` and `out_valid` are 0, and `out_valid` is never 1 while `busy` is 0.
- R2: A start with count N in [2, MAX_N] yields exactly N*(N-1) result beats, with `out_a` != `out_b` on every beat. The order is `out_a` ascending from 0, and within a group `out_b` ascends over all indices except `out_a`. The inner counter k runs 0..N-2 and the second index is k+1 when k >= `out_a`, otherwise k.
- R3: Per axis, with lo/hi the smaller/larger index and h the half box length, r = pos[lo] - pos[hi] is wrapped. When r > h the result is r - 2h, when r <= -h it is r + 2h, and otherwise it is r. The result is negated when `out_b` < `out_a`, and it is reported as a CW+2 bit two's complement value.
- R4: `out_dist2` equals the sum of the three squared displacements, and `out_hit` is 1 only when `out_dist2` is strictly less than the squared cutoff.
- R5: `out_grp_cnt` is the number of hit beats so far in the current group, this beat included. `out_grp_end` is 1 exactly on the group's last beat (k = N-2), where `out_grp_cnt` is the group total.
- R6: While `out_valid` is 1 and `out_ready` is 0 the beat is held unchanged, and no beat is lost or repeated under any ready pattern.
- R7: With `out_ready` held at 1, `out_valid` drops for the cycle after each accepted beat, and accepted beats are exactly 3 cycles apart.
- R8: `done` pulses for one cycle right after the final beat is accepted, and `busy` is 0 in that same cycle.
- R9: A start while busy has no effect, and a start with N < 2 or N > MAX_N leaves the block idle.
- R10: Coordinate writes while busy have no effect on the stored coordinates.
- R11: With N = 2 each group has one beat, which both restarts and ends the tally.
- R12: Count, half lengths and cutoff are captured at the accepted start, so later changes to those inputs do not affect the running sweep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Coordinate write strobe (honoured only when idle) |
| wr_idx | input | IW | Particle index to write |
| wr_x | input | CW | X coordinate, signed |
| wr_y | input | CW | Y coordinate, signed |
| wr_z | input | CW | Z coordinate, signed |
| n_part | input | NW | Particle count N for the next sweep |
| half_x | input | CW | Half box length, X, non-negative |
| half_y | input | CW | Half box length, Y, non-negative |
| half_z | input | CW | Half box length, Z, non-negative |
| cut_sq | input | SW | Squared cutoff distance |
| start | input | 1 | Start pulse |
| busy | output | 1 | Sweep in progress |
| done | output | 1 | One-cycle pulse after the final beat |
| out_valid | output | 1 | Result beat valid |
| out_ready | input | 1 | Consumer accepts the beat |
| out_a | output | IW | First particle index |
| out_b | output | IW | Second particle index |
| out_dx | output | DW | Wrapped X displacement, signed |
| out_dy | output | DW | Wrapped Y displacement, signed |
| out_dz | output | DW | Wrapped Z displacement, signed |
| out_dist2 | output | SW | Squared distance |
| out_hit | output | 1 | Squared distance below cutoff |
| out_grp_end | output | 1 | Last beat of the current first particle |
| out_grp_cnt | output | NW | Hits so far in the group, this beat included |

## Verification
Several stream properties are checked on every cycle: a stalled beat stays frozen, the two indices on a beat differ, valid drops after each accepted beat, no beat appears while idle, and done follows an accepted beat with busy already low. The exact pair order, the wrapped displacement values at the ±h boundaries, the strict cutoff comparison and the per-group tallies can only be shown by the bench's scenarios. The bench compares each beat against a nested-loop reference model. The same scenarios show that ignored starts and writes issued during a sweep leave the results unchanged.

// File: rtl/pair_sweep_pkg.sv
package pair_sweep_pkg;

    localparam int AXES        = 3;
    localparam int COORD_W_DEF = 24;
    localparam int MAX_N_DEF   = 1024;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_DIFF  = 2'd2,
        ST_SHOW  = 2'd3
    } seq_state_t;

    function automatic int disp_w(input int cw);
        return cw + 2;
    endfunction

    function automatic int dist_w(input int cw);
        return 2 * (cw + 2);
    endfunction

endpackage

// File: rtl/pair_coord_store.sv
module pair_coord_store
    import pair_sweep_pkg::*;
#(
    parameter int DEPTH = 1024,
    parameter int IW    = 10,
    parameter int CW    = 24
) (
    input  logic                 clk,
    input  logic                 wr_en,
    input  logic [IW-1:0]        wr_idx,
    input  logic [AXES*CW-1:0]   wr_data,
    input  logic [IW-1:0]        rd_a_idx,
    input  logic [IW-1:0]        rd_b_idx,
    output logic [AXES*CW-1:0]   rd_a_data,
    output logic [AXES*CW-1:0]   rd_b_data
);

    logic [AXES*CW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_idx] <= wr_data;
        end
    end

    assign rd_a_data = mem[rd_a_idx];
    assign rd_b_data = mem[rd_b_idx];

endmodule

// File: rtl/pair_min_image.sv
module pair_min_image #(
    parameter int CW = 24
) (
    input  logic signed [CW-1:0] lo,
    input  logic signed [CW-1:0] hi,
    input  logic signed [CW-1:0] half,
    input  logic                 flip,
    output logic signed [CW+1:0] disp
);

    localparam int DW = CW + 2;

    logic signed [DW-1:0] raw;
    logic signed [DW-1:0] h;
    logic signed [DW-1:0] sub_a;
    logic signed [DW-1:0] sub_b;
    logic signed [DW-1:0] wrapped;

    always_comb begin
        raw     = {{2{lo[CW-1]}}, lo} - {{2{hi[CW-1]}}, hi};
        h       = {{2{half[CW-1]}}, half};
        // two threshold compares, each choosing +h or -h to remove
        sub_a   = (raw > h)  ? h : -h;
        sub_b   = (raw > -h) ? h : -h;
        wrapped = raw - sub_a - sub_b;
        disp    = flip ? -wrapped : wrapped;
    end

endmodule

// File: rtl/pair_walker.sv
module pair_walker #(
    parameter int IW = 10,
    parameter int NW = 11
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          init,
    input  logic [NW-1:0] n_in,
    input  logic          step,
    output logic [IW-1:0] idx_a,
    output logic [IW-1:0] idx_b,
    output logic          grp_first,
    output logic          grp_last,
    output logic          final_pair
);

    localparam int TW = 2 * NW;

    logic [NW-1:0] n_q;
    logic [NW-1:0] inner_lim;
    logic [IW-1:0] outer_q;
    logic [IW-1:0] inner_q;
    logic [TW-1:0] left_q;

    assign inner_lim = n_q - NW'(2);

    always_ff @(posedge clk) begin
        if (rst) begin
            n_q     <= '0;
            outer_q <= '0;
            inner_q <= '0;
            left_q  <= '0;
        end else if (init) begin
            n_q     <= n_in;
            outer_q <= '0;
            inner_q <= '0;
            left_q  <= TW'(n_in) * TW'(n_in - NW'(1));
        end else if (step) begin
            left_q <= left_q - TW'(1);
            if ({1'b0, inner_q} == inner_lim) begin
                inner_q <= '0;
                outer_q <= outer_q + IW'(1);
            end else begin
                inner_q <= inner_q + IW'(1);
            end
        end
    end

    // self-skip: inner positions at or past the outer index shift up by one
    assign idx_a      = outer_q;
    assign idx_b      = (inner_q >= outer_q) ? inner_q + IW'(1) : inner_q;
    assign grp_first  = (inner_q == '0);
    assign grp_last   = ({1'b0, inner_q} == inner_lim);
    assign final_pair = (left_q == TW'(1));

endmodule

// File: rtl/pair_sweep.sv
module pair_sweep
    import pair_sweep_pkg::*;
#(
    parameter int CW    = COORD_W_DEF,
    parameter int MAX_N = MAX_N_DEF,
    parameter int IW    = $clog2(MAX_N),
    parameter int NW    = $clog2(MAX_N + 1),
    parameter int DW    = disp_w(CW),
    parameter int SW    = dist_w(CW)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [CW-1:0] wr_x,
    input  logic [CW-1:0] wr_y,
    input  logic [CW-1:0] wr_z,
    input  logic [NW-1:0] n_part,
    input  logic [CW-1:0] half_x,
    input  logic [CW-1:0] half_y,
    input  logic [CW-1:0] half_z,
    input  logic [SW-1:0] cut_sq,
    input  logic          start,
    output logic          busy,
    output logic          done,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [IW-1:0] out_a,
    output logic [IW-1:0] out_b,
    output logic [DW-1:0] out_dx,
    output logic [DW-1:0] out_dy,
    output logic [DW-1:0] out_dz,
    output logic [SW-1:0] out_dist2,
    output logic          out_hit,
    output logic          out_grp_end,
    output logic [NW-1:0] out_grp_cnt
);

    localparam int VW = AXES * CW;

    seq_state_t st_q;

    logic          accept;
    logic          beat_taken;
    logic [IW-1:0] idx_a;
    logic [IW-1:0] idx_b;
    logic          grp_first;
    logic          grp_last;
    logic          final_pair;

    logic [VW-1:0] rd_a;
    logic [VW-1:0] rd_b;
    logic [VW-1:0] pa_q;
    logic [VW-1:0] pb_q;
    logic [VW-1:0] half_q;
    logic [SW-1:0] cut_q;
    logic [NW-1:0] tally_q;

    logic                 a_is_lo;
    logic signed [DW-1:0] disp_c [AXES];
    logic signed [DW-1:0] disp_q [AXES];
    logic signed [SW-1:0] disp_ext [AXES];
    logic [SW-1:0]        sq [AXES];
    logic [SW-1:0]        dist2;

    assign accept     = (st_q == ST_IDLE) && start &&
                        (n_part >= NW'(2)) && (n_part <= NW'(MAX_N));
    assign beat_taken = (st_q == ST_SHOW) && out_ready;

    pair_coord_store #(
        .DEPTH (MAX_N),
        .IW    (IW),
        .CW    (CW)
    ) u_store (
        .clk       (clk),
        .wr_en     (wr_en && (st_q == ST_IDLE)),
        .wr_idx    (wr_idx),
        .wr_data   ({wr_z, wr_y, wr_x}),
        .rd_a_idx  (idx_a),
        .rd_b_idx  (idx_b),
        .rd_a_data (rd_a),
        .rd_b_data (rd_b)
    );

    pair_walker #(
        .IW (IW),
        .NW (NW)
    ) u_walk (
        .clk        (clk),
        .rst        (rst),
        .init       (accept),
        .n_in       (n_part),
        .step       (beat_taken),
        .idx_a      (idx_a),
        .idx_b      (idx_b),
        .grp_first  (grp_first),
        .grp_last   (grp_last),
        .final_pair (final_pair)
    );

    assign a_is_lo = (idx_a < idx_b);

    for (genvar ax = 0; ax < AXES; ax++) begin : g_axis
        pair_min_image #(
            .CW (CW)
        ) u_wrap (
            .lo   (a_is_lo ? pa_q[ax*CW +: CW] : pb_q[ax*CW +: CW]),
            .hi   (a_is_lo ? pb_q[ax*CW +: CW] : pa_q[ax*CW +: CW]),
            .half (half_q[ax*CW +: CW]),
            .flip (!a_is_lo),
            .disp (disp_c[ax])
        );

        always_comb begin
            disp_ext[ax] = SW'(disp_q[ax]);
            sq[ax]       = disp_ext[ax] * disp_ext[ax];
        end
    end

    assign dist2 = sq[0] + sq[1] + sq[2];

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_IDLE;
            done    <= 1'b0;
            pa_q    <= '0;
            pb_q    <= '0;
            half_q  <= '0;
            cut_q   <= '0;
            tally_q <= '0;
            for (int ax = 0; ax < AXES; ax++) begin
                disp_q[ax] <= '0;
            end
        end else begin
            done <= 1'b0;
            unique case (st_q)
                ST_IDLE: begin
                    if (accept) begin
                        half_q <= {half_z, half_y, half_x};
                        cut_q  <= cut_sq;
                        st_q   <= ST_FETCH;
                    end
                end
                ST_FETCH: begin
                    pa_q <= rd_a;
                    pb_q <= rd_b;
                    st_q <= ST_DIFF;
                end
                ST_DIFF: begin
                    for (int ax = 0; ax < AXES; ax++) begin
                        disp_q[ax] <= disp_c[ax];
                    end
                    st_q <= ST_SHOW;
                end
                ST_SHOW: begin
                    if (out_ready) begin
                        tally_q <= out_grp_cnt;
                        if (final_pair) begin
                            st_q <= ST_IDLE;
                            done <= 1'b1;
                        end else begin
                            st_q <= ST_FETCH;
                        end
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign busy        = (st_q != ST_IDLE);
    assign out_valid   = (st_q == ST_SHOW);
    assign out_a       = idx_a;
    assign out_b       = idx_b;
    assign out_dx      = disp_q[0];
    assign out_dy      = disp_q[1];
    assign out_dz      = disp_q[2];
    assign out_dist2   = dist2;
    assign out_hit     = (dist2 < cut_q);
    assign out_grp_end = grp_last;
    assign out_grp_cnt = (grp_first ? NW'(0) : tally_q) + NW'(out_hit);

endmodule

// File: rtl/pair_sweep_chk.sv
module pair_sweep_chk #(
    parameter int IW = 10,
    parameter int SW = 52
) (
    input logic          clk,
    input logic          rst,
    input logic          busy,
    input logic          done,
    input logic          out_valid,
    input logic          out_ready,
    input logic [IW-1:0] out_a,
    input logic [IW-1:0] out_b,
    input logic [SW-1:0] out_dist2
);

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !out_valid);

    // R2
    distinct_idx_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_a != out_b));

    // R6
    hold_on_stall_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=>
            (out_valid && $stable(out_a) && $stable(out_b) && $stable(out_dist2)));

    // R7
    gap_after_beat_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready) |=> !out_valid);

    // R8
    done_after_last_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> (!busy && $past(out_valid && out_ready)));

endmodule

bind pair_sweep pair_sweep_chk #(
    .IW (IW),
    .SW (SW)
) u_pair_sweep_chk (
    .clk       (clk),
    .rst       (rst),
    .busy      (busy),
    .done      (done),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_a     (out_a),
    .out_b     (out_b),
    .out_dist2 (out_dist2)
);

// File: tb/tb_pair_sweep.sv
module tb_pair_sweep;

    localparam int CW = 24;
    localparam int MAXN = 1024;
    localparam int IW = 10;
    localparam int NW = 11;
    localparam int DW = 26;
    localparam int SW = 52;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic [IW-1:0] wr_idx = '0;
    logic [CW-1:0] wr_x = '0, wr_y = '0, wr_z = '0;
    logic [NW-1:0] n_part = '0;
    logic [CW-1:0] half_x = '0, half_y = '0, half_z = '0;
    logic [SW-1:0] cut_sq = '0;
    logic          start = 1'b0;
    logic          busy, done, out_valid, out_hit, out_grp_end;
    logic          out_ready = 1'b1;
    logic [IW-1:0] out_a, out_b;
    logic [DW-1:0] out_dx, out_dy, out_dz;
    logic [SW-1:0] out_dist2;
    logic [NW-1:0] out_grp_cnt;

    always #4 clk = ~clk;

    pair_sweep dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_x(wr_x), .wr_y(wr_y), .wr_z(wr_z), .n_part(n_part),
        .half_x(half_x), .half_y(half_y), .half_z(half_z), .cut_sq(cut_sq),
        .start(start), .busy(busy), .done(done), .out_valid(out_valid),
        .out_ready(out_ready), .out_a(out_a), .out_b(out_b),
        .out_dx(out_dx), .out_dy(out_dy), .out_dz(out_dz),
        .out_dist2(out_dist2), .out_hit(out_hit),
        .out_grp_end(out_grp_end), .out_grp_cnt(out_grp_cnt)
    );

    typedef struct {
        int     a;
        int     b;
        longint d [3];
        longint r2;
        bit     hit;
        bit     gend;
        int     gcnt;
    } exp_t;

    exp_t   q [$];
    longint pos [16][3];
    longint hv [3];
    longint cut_v;
    int     n_tests = 0;
    int     n_fail = 0;
    bit     ready_rand = 1'b0;
    int     cyc = 0;
    int     last_hs = -1;
    int     beats = 0;
    bit     hold_pend = 1'b0;
    logic [IW-1:0] h_a, h_b;
    logic [SW-1:0] h_d2;
    logic [DW-1:0] h_dx;
    int unsigned seed = 32'h1234_5678;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    function automatic longint wrap(input longint r, input longint h);
        longint s1, s2;
        s1 = (r > h) ? h : -h;
        s2 = (r > -h) ? h : -h;
        return r - s1 - s2;
    endfunction

    // reference nested-loop model
    task automatic build(input int n);
        int cnt;
        for (int a = 0; a < n; a++) begin
            cnt = 0;
            for (int b = 0; b < n; b++) begin
                exp_t e;
                int lo, hi;
                if (a == b) continue;
                lo = (a < b) ? a : b;
                hi = (a < b) ? b : a;
                e.a = a;
                e.b = b;
                e.r2 = 0;
                for (int ax = 0; ax < 3; ax++) begin
                    e.d[ax] = wrap(pos[lo][ax] - pos[hi][ax], hv[ax]);
                    if (b < a) e.d[ax] = -e.d[ax];
                    e.r2 += e.d[ax] * e.d[ax];
                end
                e.hit = (e.r2 < cut_v);
                cnt += int'(e.hit);
                e.gcnt = cnt;
                e.gend = (a == n - 1) ? (b == n - 2) : (b == n - 1);
                q.push_back(e);
            end
        end
    endtask

    task automatic load(input int i, input longint x, input longint y, input longint z);
        pos[i][0] = x; pos[i][1] = y; pos[i][2] = z;
        @(posedge clk); #1;
        wr_en = 1'b1; wr_idx = IW'(i);
        wr_x = x[CW-1:0]; wr_y = y[CW-1:0]; wr_z = z[CW-1:0];
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    function automatic longint rnd();
        seed = seed * 32'd1103515245 + 32'd12345;
        return longint'((seed >> 8) % 4001) - 2000;
    endfunction

    task automatic run(input int n, input bit rmode, input bit poke);
        build(n);
        ready_rand = rmode;
        last_hs = -1;
        beats = 0;
        @(posedge clk); #1;
        n_part = NW'(n);
        half_x = hv[0][CW-1:0]; half_y = hv[1][CW-1:0]; half_z = hv[2][CW-1:0];
        cut_sq = cut_v[SW-1:0];
        start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        if (poke) begin
            repeat (5) @(posedge clk);
            #1;
            // R9 start while busy, R10 write while busy, R12 inputs changed mid-run
            start = 1'b1; n_part = NW'(2); wr_en = 1'b1; wr_idx = IW'(n - 1);
            wr_x = 24'd777; wr_y = 24'd777; wr_z = 24'd777;
            half_x = '0; cut_sq = '0;
            @(posedge clk); #1;
            start = 1'b0; wr_en = 1'b0;
        end
        do @(negedge clk); while (!done && cyc < 150000);
        // R8 done with busy already low
        check(busy == 1'b0, "R8", "busy at done", longint'(busy), 0);
        check(q.size() == 0, "R2", "leftover expected beats", q.size(), 0);
        check(beats == n * (n - 1), "R2", "beat count", beats, n * (n - 1));
        @(negedge clk);
        check(done == 1'b0, "R8", "done pulse width", longint'(done), 0);
    endtask

    task automatic bad_start(input int n);
        @(posedge clk); #1;
        n_part = NW'(n); start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        repeat (4) @(negedge clk);
        check(busy == 1'b0 && out_valid == 1'b0, "R9", "idle after bad count", n, 0);
    endtask

    // ready driver
    initial begin
        logic [15:0] lf = 16'hACE1;
        forever begin
            @(posedge clk); #1;
            if (ready_rand) begin
                lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
                out_ready = lf[0];
            end else begin
                out_ready = 1'b1;
            end
        end
    end

    // scoreboard monitor
    always @(negedge clk) begin
        cyc++;
        if (!rst) begin
            if (hold_pend) begin
                check(out_valid && out_a == h_a && out_b == h_b &&
                      out_dist2 == h_d2 && out_dx == h_dx,
                      "R6", "beat held under stall", longint'(out_dist2), longint'(h_d2));
            end
            if (out_valid && out_ready) begin
                beats++;
                if (q.size() == 0) begin
                    check(1'b0, "R2", "unexpected beat a", out_a, -1);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    check(out_a == IW'(e.a) && out_b == IW'(e.b), "R2", "pair order b",
                          out_b, e.b);
                    check(longint'($signed(out_dx)) == e.d[0] &&
                          longint'($signed(out_dy)) == e.d[1] &&
                          longint'($signed(out_dz)) == e.d[2], "R3", "wrapped dx",
                          longint'($signed(out_dx)), e.d[0]);
                    check(longint'(out_dist2) == e.r2 && out_hit == e.hit, "R4",
                          "dist2", longint'(out_dist2), e.r2);
                    check(out_grp_end == e.gend && out_grp_cnt == NW'(e.gcnt), "R5",
                          "group tally", out_grp_cnt, e.gcnt);
                end
                if (!ready_rand && last_hs >= 0) begin
                    check(cyc - last_hs == 3, "R7", "beat spacing", cyc - last_hs, 3);
                end
                last_hs = cyc;
            end
            hold_pend = out_valid && !out_ready;
            h_a = out_a; h_b = out_b; h_d2 = out_dist2; h_dx = out_dx;
        end
    end

    // watchdog
    initial begin
        wait (cyc >= 150000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R1
        check(busy == 0 && done == 0 && out_valid == 0, "R1", "reset state",
              longint'({busy, done, out_valid}), 0);

        // R11 two particles, strict cutoff at and just above r2
        hv[0] = 1500; hv[1] = 1500; hv[2] = 1500;
        load(0, 100, -200, 50);
        load(1, -300, 400, 10);
        cut_v = 521600;
        run(2, 1'b0, 1'b0);
        cut_v = 521601;
        run(2, 1'b0, 1'b0);

        // R3 displacements landing exactly on +-h and beyond
        hv[0] = 1000; hv[1] = 1000; hv[2] = 700;
        load(0, 0, 0, 0);
        load(1, 1000, 1001, -700);
        load(2, -1000, -1001, 700);
        cut_v = 1000000;
        run(3, 1'b0, 1'b0);

        // R9 invalid counts
        bad_start(1);
        bad_start(0);
        bad_start(MAXN + 1);

        // random coordinates, free-running consumer
        hv[0] = 1500; hv[1] = 1200; hv[2] = 1700;
        for (int i = 0; i < 8; i++) load(i, rnd(), rnd(), rnd());
        cut_v = 2000000;
        run(6, 1'b0, 1'b0);

        // R6 random back-pressure with R9/R10/R12 pokes mid-run
        run(8, 1'b1, 1'b1);

        // R10 store still holds the values from before the ignored write
        run(8, 1'b0, 1'b0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule